// File: doc/BRIEF.md
# Power-Management Event Status and SCI Generator

This block keeps the sticky status flags and the enable masks for two groups of power-management events. The fixed group covers the timer overflow, the global-lock release, the power button and the RTC alarm. The general-purpose group is one byte of event flags, and two of its bits report PCI and CPU hotplug. An event pulse on an input sets its status flag. Firmware reads the flags and enables through a byte-wide register port, and writes a 1 to a status flag to clear it. The SCI output is a level. It is high while any enabled flag that is allowed to interrupt is set.

The block also watches writes to the APM command port. One command value switches ACPI mode on and another switches it off. When a configuration input allows it, every APM command write also produces a one-cycle SMI pulse. A timer-arm output tells the external PM timer whether an overflow should still be tracked.

Top module: `acpi_evt_sci`

## Requirements
- R1: Register map on `reg_addr`, all reads combinational:
  - 0 reads the fixed-group status: bit0 timer overflow, bit1 global lock, bit2 power button, bit3 RTC alarm, bits 7:4 zero.
  - 1 reads the fixed-group enables in the same bit positions.
  - 2 reads the general-purpose status byte.
  - 3 reads the general-purpose enable byte.
  - 4 reads the mode byte, with bit0 as ACPI mode and the other bits zero.
  - Addresses 5 to 7 read zero.
- R2: A write to address 0 or 2 clears each status bit whose data bit is 1 and leaves the others. A write to address 1 or 3 replaces the enable bits. Writes to addresses 4 to 7 change no register.
- R3: A high `pm_evt[i]` or `gpe_evt[i]` in a cycle sets the matching status bit from the next cycle on, and the bit stays set until it is cleared. `pwrdn_req` sets the power-button status bit (bit2).
- R4: `sci` is high whenever any of the four fixed-group status bits is set together with its enable bit.
- R5: `sci` is also high whenever general-purpose status bit1 or bit2 is set together with its enable bit. The other general-purpose bits never raise `sci`.
- R6: An APM write of 8'hF1 turns ACPI mode on from the next cycle, and 8'hF0 turns it off. Other values leave the mode unchanged.
- R7: `smi` is high for exactly the cycle after each APM write made while `cfg_smi_en` is high. It is never high otherwise.
- R8: `tmr_armed` is high exactly when the timer enable (address 1, bit0) is set and the timer status (address 0, bit0) is clear.
- R9: When an event sets a status bit in the same cycle as a write-1-to-clear of that bit, the bit ends up set.
- R10: Reset clears every status bit, every enable bit, ACPI mode and `smi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_evt | input | 4 | Fixed-group event pulses (timer, global lock, power button, RTC) |
| pwrdn_req | input | 1 | Power-down request; sets the power-button status |
| gpe_evt | input | 8 | General-purpose event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| apm_wr | input | 1 | APM command write strobe |
| apm_data | input | 8 | APM command value |
| cfg_smi_en | input | 1 | Allows an SMI pulse on APM writes |
| acpi_en | output | 1 | ACPI mode state |
| sci | output | 1 | Level-sensitive SCI |
| smi | output | 1 | One-cycle SMI pulse |
| tmr_armed | output | 1 | Timer overflow tracking armed |

## Verification
The assertions check the following on every cycle:
- the ACPI-mode transitions on the two APM command values and the hold on all other cycles;
- that an SMI pulse appears after, and only after, an allowed APM write;
- that a power-down request always leaves the power-button flag set;
- that the SCI and timer-arm outputs never rise without a matching enable.

Some behaviour only the bench scenarios can show:
- the exact masking that keeps general-purpose bits outside 1 and 2 off the SCI;
- that write-1-to-clear leaves the other bits alone;
- that a set wins over a clear in the same cycle;
- the read-back values of the whole map.

The bench compares these against its reference model on every clock.

// File: rtl/acpi_evt_pkg.sv
package acpi_evt_pkg;
    localparam int PM_BITS  = 4;
    localparam int GPE_BITS = 8;
    localparam int ADDR_W   = 3;

    localparam int PM_TMR_BIT = 0;
    localparam int PM_GBL_BIT = 1;
    localparam int PM_PWR_BIT = 2;
    localparam int PM_RTC_BIT = 3;

    localparam logic [ADDR_W-1:0] A_PM_STS  = 3'd0;
    localparam logic [ADDR_W-1:0] A_PM_EN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_GPE_STS = 3'd2;
    localparam logic [ADDR_W-1:0] A_GPE_EN  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MODE    = 3'd4;

    localparam logic [7:0] APM_CMD_ON  = 8'hF1;
    localparam logic [7:0] APM_CMD_OFF = 8'hF0;

    localparam logic [PM_BITS-1:0]  PM_SCI_MASK  = 4'b1111;
    localparam logic [GPE_BITS-1:0] GPE_SCI_MASK = 8'b0000_0110;

    typedef struct packed {
        logic acpi_en;
        logic smi;
    } apm_state_t;
endpackage

// File: rtl/acpi_sts_bank.sv
module acpi_sts_bank #(
    parameter int           W        = 4,
    parameter logic [W-1:0] SCI_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_sts_i,
    input  logic         wr_en_i,
    input  logic [7:0]   wdata_i,
    output logic [W-1:0] sts_o,
    output logic [W-1:0] en_o,
    output logic         hit_o
);
    typedef struct packed {
        logic [W-1:0] sts;
        logic [W-1:0] en;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_sts_i) begin
            bank_d.sts = bank_q.sts & ~wdata_i[W-1:0];
        end
        if (wr_en_i) begin
            bank_d.en = wdata_i[W-1:0];
        end
        bank_d.sts = bank_d.sts | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign sts_o = bank_q.sts;
    assign en_o  = bank_q.en;
    assign hit_o = |(bank_q.sts & bank_q.en & SCI_MASK);
endmodule

// File: rtl/acpi_apm_ctl.sv
module acpi_apm_ctl
    import acpi_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       apm_wr_i,
    input  logic [7:0] apm_data_i,
    input  logic       smi_allow_i,
    output logic       acpi_en_o,
    output logic       smi_o
);
    apm_state_t apm_d, apm_q;

    always_comb begin
        apm_d     = apm_q;
        apm_d.smi = apm_wr_i & smi_allow_i;
        if (apm_wr_i) begin
            if (apm_data_i == APM_CMD_ON) begin
                apm_d.acpi_en = 1'b1;
            end else if (apm_data_i == APM_CMD_OFF) begin
                apm_d.acpi_en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            apm_q <= '0;
        end else begin
            apm_q <= apm_d;
        end
    end

    assign acpi_en_o = apm_q.acpi_en;
    assign smi_o     = apm_q.smi;
endmodule

// File: rtl/acpi_evt_sci.sv
module acpi_evt_sci
    import acpi_evt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PM_BITS-1:0]  pm_evt,
    input  logic                pwrdn_req,
    input  logic [GPE_BITS-1:0] gpe_evt,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic                apm_wr,
    input  logic [7:0]          apm_data,
    input  logic                cfg_smi_en,
    output logic                acpi_en,
    output logic                sci,
    output logic                smi,
    output logic                tmr_armed
);
    logic [PM_BITS-1:0]  pm_set_w, pm_sts_w, pm_en_w;
    logic [GPE_BITS-1:0] gpe_sts_w, gpe_en_w;
    logic                pm_hit_w, gpe_hit_w;

    always_comb begin
        pm_set_w             = pm_evt;
        pm_set_w[PM_PWR_BIT] = pm_evt[PM_PWR_BIT] | pwrdn_req;
    end

    acpi_sts_bank #(.W(PM_BITS), .SCI_MASK(PM_SCI_MASK)) u_pm_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (pm_set_w),
        .wr_sts_i (reg_we && reg_addr == A_PM_STS),
        .wr_en_i  (reg_we && reg_addr == A_PM_EN),
        .wdata_i  (reg_wdata),
        .sts_o    (pm_sts_w),
        .en_o     (pm_en_w),
        .hit_o    (pm_hit_w)
    );

    acpi_sts_bank #(.W(GPE_BITS), .SCI_MASK(GPE_SCI_MASK)) u_gpe_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (gpe_evt),
        .wr_sts_i (reg_we && reg_addr == A_GPE_STS),
        .wr_en_i  (reg_we && reg_addr == A_GPE_EN),
        .wdata_i  (reg_wdata),
        .sts_o    (gpe_sts_w),
        .en_o     (gpe_en_w),
        .hit_o    (gpe_hit_w)
    );

    acpi_apm_ctl u_apm (
        .clk         (clk),
        .rst_n       (rst_n),
        .apm_wr_i    (apm_wr),
        .apm_data_i  (apm_data),
        .smi_allow_i (cfg_smi_en),
        .acpi_en_o   (acpi_en),
        .smi_o       (smi)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_PM_STS:  reg_rdata[PM_BITS-1:0]  = pm_sts_w;
            A_PM_EN:   reg_rdata[PM_BITS-1:0]  = pm_en_w;
            A_GPE_STS: reg_rdata[GPE_BITS-1:0] = gpe_sts_w;
            A_GPE_EN:  reg_rdata[GPE_BITS-1:0] = gpe_en_w;
            A_MODE:    reg_rdata[0]            = acpi_en;
            default:   reg_rdata = '0;
        endcase
    end

    assign sci       = pm_hit_w | gpe_hit_w;
    assign tmr_armed = pm_en_w[PM_TMR_BIT] & ~pm_sts_w[PM_TMR_BIT];
endmodule

// File: rtl/acpi_evt_sci_chk.sv
module acpi_evt_sci_chk
    import acpi_evt_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                apm_wr,
    input logic [7:0]          apm_data,
    input logic                cfg_smi_en,
    input logic                acpi_en,
    input logic                smi,
    input logic                pwrdn_req,
    input logic [PM_BITS-1:0]  pm_sts,
    input logic [PM_BITS-1:0]  pm_en,
    input logic [GPE_BITS-1:0] gpe_en,
    input logic                sci,
    input logic                tmr_armed
);
    AST_MODE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && apm_data == APM_CMD_ON) |=> acpi_en); // R6
    AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && apm_data == APM_CMD_OFF) |=> !acpi_en); // R6
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!apm_wr || (apm_data != APM_CMD_ON && apm_data != APM_CMD_OFF)) |=> $stable(acpi_en)); // R6
    AST_SMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && cfg_smi_en) |=> smi); // R7
    AST_SMI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(apm_wr && cfg_smi_en) |=> !smi); // R7
    AST_PWRDN_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_req |=> pm_sts[PM_PWR_BIT]); // R3
    AST_SCI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        sci |-> ((|pm_en) || (|gpe_en))); // R4
    AST_TMR_ARM_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_armed |-> pm_en[PM_TMR_BIT]); // R8
endmodule

bind acpi_evt_sci acpi_evt_sci_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .apm_wr     (apm_wr),
    .apm_data   (apm_data),
    .cfg_smi_en (cfg_smi_en),
    .acpi_en    (acpi_en),
    .smi        (smi),
    .pwrdn_req  (pwrdn_req),
    .pm_sts     (pm_sts_w),
    .pm_en      (pm_en_w),
    .gpe_en     (gpe_en_w),
    .sci        (sci),
    .tmr_armed  (tmr_armed)
);

// File: tb/acpi_evt_sci_bench.sv
`timescale 1ns/100ps
module acpi_evt_sci_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pm_evt = '0;
    logic       pwrdn_req = 1'b0;
    logic [7:0] gpe_evt = '0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       apm_wr = 1'b0;
    logic [7:0] apm_data = '0;
    logic       cfg_smi_en = 1'b0;
    logic       acpi_en, sci, smi, tmr_armed;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    int m_pm_sts = 0, m_pm_en = 0, m_gpe_sts = 0, m_gpe_en = 0;
    bit m_mode = 0, m_smi = 0;

    always #2 clk = ~clk;

    acpi_evt_sci u_acpi_evt_sci (
        .clk(clk), .rst_n(rst_n), .pm_evt(pm_evt), .pwrdn_req(pwrdn_req),
        .gpe_evt(gpe_evt), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .apm_wr(apm_wr),
        .apm_data(apm_data), .cfg_smi_en(cfg_smi_en), .acpi_en(acpi_en),
        .sci(sci), .smi(smi), .tmr_armed(tmr_armed)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_rd(input int a);
        case (a)
            0: return m_pm_sts;
            1: return m_pm_en;
            2: return m_gpe_sts;
            3: return m_gpe_en;
            4: return int'(m_mode);
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_sci();
        return ((m_pm_sts & m_pm_en & 'hF) != 0) || ((m_gpe_sts & m_gpe_en & 'h6) != 0);
    endfunction

    // model update on each edge from the inputs held since the last drive
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pm_sts <= 0; m_pm_en <= 0; m_gpe_sts <= 0; m_gpe_en <= 0;
            m_mode <= 0; m_smi <= 0;
        end else begin
            int ps = m_pm_sts, gs = m_gpe_sts;
            if (reg_we && reg_addr == 0) ps = ps & ~int'(reg_wdata);
            if (reg_we && reg_addr == 2) gs = gs & ~int'(reg_wdata);
            ps = (ps | int'(pm_evt) | (pwrdn_req ? 4 : 0)) & 'hF;
            gs = (gs | int'(gpe_evt)) & 'hFF;
            m_pm_sts  <= ps;
            m_gpe_sts <= gs;
            if (reg_we && reg_addr == 1) m_pm_en  <= int'(reg_wdata) & 'hF;
            if (reg_we && reg_addr == 3) m_gpe_en <= int'(reg_wdata);
            if (apm_wr && apm_data == 8'hF1) m_mode <= 1;
            else if (apm_wr && apm_data == 8'hF0) m_mode <= 0;
            m_smi <= apm_wr && cfg_smi_en;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(sci == exp_sci(), "R4/R5 sci", sci, exp_sci());
            check(smi == m_smi, "R7 smi", smi, m_smi);
            check(acpi_en == m_mode, "R6 acpi_en", acpi_en, m_mode);
            check(tmr_armed == ((m_pm_en & 1) && !(m_pm_sts & 1)), "R8 tmr_armed",
                  tmr_armed, (m_pm_en & 1) && !(m_pm_sts & 1));
            check(int'(reg_rdata) == exp_rd(int'(reg_addr)), "R1 rdata",
                  reg_rdata, exp_rd(int'(reg_addr)));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input int d);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = 3'(a);
        #0.2;
        d = int'(reg_rdata);
    endtask

    task automatic apm(input int d, input bit allow);
        apm_wr = 1'b1; apm_data = 8'(d); cfg_smi_en = allow;
        tick();
        apm_wr = 1'b0; cfg_smi_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int v;
        #5 rst_n = 1'b1;
        tick();
        // R10: reset state
        for (int a = 0; a < 8; a++) begin
            rd(a, v);
            check(v == 0, "R10 reset register", v, 0);
        end
        check(sci == 0 && smi == 0 && acpi_en == 0, "R10 reset outputs", {sci, smi, acpi_en}, 0);

        // R3 / R4: power button without and with enable
        pm_evt = 4'b0100; tick(); pm_evt = '0;
        check(sci == 0, "R4 masked event", sci, 0);
        rd(0, v); check(v == 4, "R3 sticky status", v, 4);
        wr(1, 4);
        check(sci == 1, "R4 enabled power button", sci, 1);
        // R2: clearing another bit leaves it, clearing bit2 drops SCI
        wr(0, 8'h0B);
        rd(0, v); check(v == 4, "R2 w1c other bits", v, 4);
        wr(0, 4);
        check(sci == 0, "R2 w1c clears", sci, 0);

        // R4: each fixed source
        wr(1, 'hF);
        for (int b = 0; b < 4; b++) begin
            pm_evt = 4'(1 << b); tick(); pm_evt = '0;
            check(sci == 1, "R4 fixed source", b, 1);
            wr(0, 1 << b);
            check(sci == 0, "R4 source cleared", b, 0);
        end
        wr(1, 0);

        // R5: general-purpose hotplug bits and a non-SCI bit
        wr(3, 'hFF);
        gpe_evt = 8'h20; tick(); gpe_evt = '0;
        check(sci == 0, "R5 bit5 no sci", sci, 0);
        rd(2, v); check(v == 'h20, "R5 bit5 status", v, 'h20);
        gpe_evt = 8'h02; tick(); gpe_evt = '0;
        check(sci == 1, "R5 pci hotplug", sci, 1);
        wr(2, 'h02);
        gpe_evt = 8'h04; tick(); gpe_evt = '0;
        check(sci == 1, "R5 cpu hotplug", sci, 1);
        wr(3, 'hFB);
        check(sci == 0, "R5 mask off", sci, 0);
        wr(2, 'hFF); wr(3, 0);

        // R9: set and clear together
        reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h08; pm_evt = 4'b1000;
        tick();
        reg_we = 1'b0; pm_evt = '0;
        rd(0, v); check(v == 8, "R9 set wins", v, 8);
        wr(0, 8);

        // R3: power-down request
        pwrdn_req = 1'b1; tick(); pwrdn_req = 1'b0;
        rd(0, v); check(v == 4, "R3 power-down", v, 4);
        wr(0, 4);

        // R6 / R7: APM commands
        apm('hF1, 1'b1);
        check(acpi_en == 1 && smi == 1, "R6 on with R7 pulse", {acpi_en, smi}, 3);
        tick();
        check(smi == 0, "R7 single cycle", smi, 0);
        apm('h55, 1'b0);
        check(acpi_en == 1 && smi == 0, "R6 other value", {acpi_en, smi}, 2);
        wr(4, 0);
        rd(4, v); check(v == 1, "R2 mode read-only", v, 1);
        apm('hF0, 1'b0);
        check(acpi_en == 0 && smi == 0, "R6 off no smi", {acpi_en, smi}, 0);

        // R8: timer arming
        wr(1, 1);
        check(tmr_armed == 1, "R8 armed", tmr_armed, 1);
        pm_evt = 4'b0001; tick(); pm_evt = '0;
        check(tmr_armed == 0, "R8 disarmed by status", tmr_armed, 0);
        wr(0, 1);
        check(tmr_armed == 1, "R8 rearmed", tmr_armed, 1);
        wr(1, 0);

        // random traffic, compared by the model every cycle
        for (int i = 0; i < 3000; i++) begin
            pm_evt    = ($urandom % 6 == 0) ? 4'($urandom) : '0;
            gpe_evt   = ($urandom % 6 == 0) ? 8'($urandom) : '0;
            pwrdn_req = ($urandom % 20 == 0);
            reg_we    = ($urandom % 3 == 0);
            reg_addr  = 3'($urandom);
            reg_wdata = 8'($urandom);
            apm_wr    = ($urandom % 8 == 0);
            case ($urandom % 3)
                0: apm_data = 8'hF0;
                1: apm_data = 8'hF1;
                default: apm_data = 8'($urandom);
            endcase
            cfg_smi_en = $urandom % 2 == 0;
            tick();
        end
        pm_evt = '0; gpe_evt = '0; pwrdn_req = 0; reg_we = 0; apm_wr = 0;
        tick();
        finish_run();
    end
endmodule